// File: doc/BRIEF.md
# Channel Window Address Decoder for a CSR Bus

This block is the slave-side address decoder in front of a control/status register space. It has one Wishbone master port, one port to the main register bank and four ports to identical per-channel register sets. Addresses in the low part of the space go to the main bank unchanged. Four fixed 32-byte windows go to the channel ports, with the address rebased to the start of the window. A channel register set can therefore be a single sub-map instantiated four times, instead of four hand-copied register groups.

The decoder follows the classic handshake with one transfer outstanding. Stall is driven while a request waits for its acknowledge. The address seen when a transfer is accepted fixes the routing until that transfer is acknowledged. Addresses that map to nothing, including the two spare words at the end of each window, are answered by the decoder itself, so the bus never hangs.

Top module: `csr_chan_decoder`

## Requirements
- R1: A byte address below 0x80 strobes only the main bank port, and that port receives the address unchanged.
- R2: Channel k (k = 0..3, where k = 0 is the first channel) owns byte addresses 0x80 + 0x40*k up to 0x80 + 0x40*k + 0x1F. Its port receives the 5-bit offset within that window on `ch_adr`. Writing different values to the same offset in the four windows and in the main bank leaves five independent values.
- R3: At most one subordinate port carries cyc/stb in any cycle, and a port that is not selected sees both low.
- R4: Acknowledge and read data returned to the master come only from the selected target. An acknowledge is only returned in the cycle after a cycle that held a request.
- R5: Offsets 0x18 and 0x1C inside a window, the gaps between windows and addresses from 0x160 upward are acknowledged by the decoder one cycle after the request. The read data is zero, no subordinate is strobed, and a write there changes no register.
- R6: `m_stall` is high in every cycle with cyc and stb high and no acknowledge, and low when no request is present.
- R7: The target chosen when a transfer is accepted stays selected until its acknowledge, even if `m_adr` changes during the transfer.
- R8: `m_err` and `m_rty` are always low.
- R9: A request held high across an acknowledge is decoded again from the current address. No acknowledge is given in the cycle that follows an acknowledge.
- R10: After reset, with no request, all subordinate strobes, acknowledge and stall are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_cyc | input | 1 | Master bus cycle |
| m_stb | input | 1 | Master strobe |
| m_we | input | 1 | Master write enable |
| m_adr | input | ADR_W (9) | Master byte address |
| m_dat_w | input | DW (32) | Master write data |
| m_dat_r | output | DW (32) | Read data to master |
| m_ack | output | 1 | Acknowledge to master |
| m_stall | output | 1 | Stall to master |
| m_err | output | 1 | Error, held low |
| m_rty | output | 1 | Retry, held low |
| b_cyc | output | 1 | Main bank cycle |
| b_stb | output | 1 | Main bank strobe |
| b_we | output | 1 | Main bank write enable |
| b_adr | output | ADR_W (9) | Main bank byte address |
| b_dat_w | output | DW (32) | Main bank write data |
| b_dat_r | input | DW (32) | Main bank read data |
| b_ack | input | 1 | Main bank acknowledge |
| c_cyc | output | NCH (4) | Per-channel cycle |
| c_stb | output | NCH (4) | Per-channel strobe |
| ch_we | output | 1 | Shared channel write enable |
| ch_adr | output | 5 | Shared channel byte offset within the window |
| ch_dat_w | output | DW (32) | Shared channel write data |
| c_dat_r | input | NCH*DW (128) | Per-channel read data, channel k at bits 32k+31:32k |
| c_ack | input | NCH (4) | Per-channel acknowledge |

## Verification
Two functions meet in one cycle. The acknowledge that ends one transfer arrives while the master keeps its request high and moves the address to another window. In that cycle the held route must release, and a fresh decode must take effect in the next cycle. The bench provokes this with back-to-back reads from two different channels, and with a mid-transfer address change towards the main bank. It judges both by the returned data, by the absence of a stray acknowledge and strobe, and by reading back the registers that a misrouted write would have overwritten.

// File: rtl/csr_dec_pkg.sv
package csr_dec_pkg;

  typedef enum logic [1:0] {
    TGT_MAIN = 2'd0,
    TGT_CHAN = 2'd1,
    TGT_NONE = 2'd2
  } tgt_kind_e;

  typedef struct packed {
    tgt_kind_e  kind;
    logic [7:0] chan;
  } route_t;

endpackage

// File: rtl/csr_win_decode.sv
module csr_win_decode
  import csr_dec_pkg::*;
#(
  parameter int unsigned ADR_W      = 9,
  parameter int unsigned NCH        = 4,
  parameter int unsigned MAIN_LIMIT = 'h80,
  parameter int unsigned WIN_BASE   = 'h80,
  parameter int unsigned WIN_STRIDE = 'h40,
  parameter int unsigned WIN_BYTES  = 32,
  parameter int unsigned POP_BYTES  = 24,
  localparam int unsigned OFF_W     = $clog2(WIN_BYTES)
) (
  input  logic [ADR_W-1:0] adr,
  output route_t           route,
  output logic [OFF_W-1:0] off
);

  logic [NCH-1:0]   hit;
  logic [NCH-1:0]   pop;
  logic [ADR_W-1:0] rel [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_win
    localparam logic [ADR_W-1:0] LO = ADR_W'(WIN_BASE + i * WIN_STRIDE);
    assign rel[i] = adr - LO;
    assign hit[i] = (adr >= LO) && (rel[i] < ADR_W'(WIN_BYTES));
    assign pop[i] = rel[i] < ADR_W'(POP_BYTES);
  end

  always_comb begin
    route = '{kind: TGT_NONE, chan: 8'd0};
    off   = adr[OFF_W-1:0];
    if (adr < ADR_W'(MAIN_LIMIT)) begin
      route.kind = TGT_MAIN;
    end
    for (int i = 0; i < NCH; i++) begin
      if (hit[i]) begin
        off = rel[i][OFF_W-1:0];
        if (pop[i]) begin
          route.kind = TGT_CHAN;
          route.chan = 8'(i);
        end
      end
    end
  end

endmodule

// File: rtl/csr_route_hold.sv
module csr_route_hold #(
  parameter int unsigned ADR_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc,
  input  logic             req,
  input  logic             ack,
  input  logic [ADR_W-1:0] adr_in,
  input  logic             no_target,
  output logic [ADR_W-1:0] adr_cur,
  output logic             null_ack
);

  logic             busy_q, busy_n;
  logic [ADR_W-1:0] adr_q;
  logic             capture;
  logic             null_q, null_n;

  always_comb begin
    capture = req & ~busy_q;
    busy_n  = cyc & (busy_q | req) & ~ack;
    adr_cur = busy_q ? adr_q : adr_in;
    null_n  = req & no_target & ~null_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      null_q <= 1'b0;
      adr_q  <= '0;
    end else begin
      busy_q <= busy_n;
      null_q <= null_n;
      if (capture) begin
        adr_q <= adr_in;
      end
    end
  end

  assign null_ack = null_q;

endmodule

// File: rtl/csr_resp_mux.sv
module csr_resp_mux
  import csr_dec_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 32
) (
  input  route_t            route,
  input  logic [NCH-1:0]    c_ack,
  input  logic [NCH*DW-1:0] c_dat_r,
  input  logic              b_ack,
  input  logic [DW-1:0]     b_dat_r,
  input  logic              null_ack,
  output logic              ack,
  output logic [DW-1:0]     dat_r
);

  always_comb begin
    ack   = 1'b0;
    dat_r = '0;
    unique case (route.kind)
      TGT_MAIN: begin
        ack   = b_ack;
        dat_r = b_dat_r;
      end
      TGT_CHAN: begin
        for (int i = 0; i < NCH; i++) begin
          if (route.chan == 8'(i)) begin
            ack   = c_ack[i];
            dat_r = c_dat_r[i*DW +: DW];
          end
        end
      end
      default: begin
        ack = null_ack;
      end
    endcase
  end

endmodule

// File: rtl/csr_chan_decoder.sv
module csr_chan_decoder
  import csr_dec_pkg::*;
#(
  parameter int unsigned ADR_W      = 9,
  parameter int unsigned DW         = 32,
  parameter int unsigned NCH        = 4,
  parameter int unsigned MAIN_LIMIT = 'h80,
  parameter int unsigned WIN_BASE   = 'h80,
  parameter int unsigned WIN_STRIDE = 'h40,
  parameter int unsigned WIN_BYTES  = 32,
  parameter int unsigned POP_BYTES  = 24,
  localparam int unsigned OFF_W     = $clog2(WIN_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_cyc,
  input  logic              m_stb,
  input  logic              m_we,
  input  logic [ADR_W-1:0]  m_adr,
  input  logic [DW-1:0]     m_dat_w,
  output logic [DW-1:0]     m_dat_r,
  output logic              m_ack,
  output logic              m_stall,
  output logic              m_err,
  output logic              m_rty,
  output logic              b_cyc,
  output logic              b_stb,
  output logic              b_we,
  output logic [ADR_W-1:0]  b_adr,
  output logic [DW-1:0]     b_dat_w,
  input  logic [DW-1:0]     b_dat_r,
  input  logic              b_ack,
  output logic [NCH-1:0]    c_cyc,
  output logic [NCH-1:0]    c_stb,
  output logic              ch_we,
  output logic [OFF_W-1:0]  ch_adr,
  output logic [DW-1:0]     ch_dat_w,
  input  logic [NCH*DW-1:0] c_dat_r,
  input  logic [NCH-1:0]    c_ack
);

  logic             req;
  logic [ADR_W-1:0] adr_cur;
  logic             null_ack;
  logic             no_target;
  route_t           route;
  logic [OFF_W-1:0] off;

  assign req       = m_cyc & m_stb;
  assign no_target = (route.kind == TGT_NONE);

  csr_route_hold #(.ADR_W(ADR_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc       (m_cyc),
    .req       (req),
    .ack       (m_ack),
    .adr_in    (m_adr),
    .no_target (no_target),
    .adr_cur   (adr_cur),
    .null_ack  (null_ack)
  );

  csr_win_decode #(
    .ADR_W(ADR_W), .NCH(NCH), .MAIN_LIMIT(MAIN_LIMIT), .WIN_BASE(WIN_BASE),
    .WIN_STRIDE(WIN_STRIDE), .WIN_BYTES(WIN_BYTES), .POP_BYTES(POP_BYTES)
  ) u_dec (
    .adr   (adr_cur),
    .route (route),
    .off   (off)
  );

  csr_resp_mux #(.NCH(NCH), .DW(DW)) u_mux (
    .route    (route),
    .c_ack    (c_ack),
    .c_dat_r  (c_dat_r),
    .b_ack    (b_ack),
    .b_dat_r  (b_dat_r),
    .null_ack (null_ack),
    .ack      (m_ack),
    .dat_r    (m_dat_r)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_strobe
    logic sel;
    assign sel      = (route.kind == TGT_CHAN) && (route.chan == 8'(i));
    assign c_cyc[i] = m_cyc & sel;
    assign c_stb[i] = m_stb & sel;
  end

  assign b_cyc    = m_cyc & (route.kind == TGT_MAIN);
  assign b_stb    = m_stb & (route.kind == TGT_MAIN);
  assign b_we     = m_we;
  assign b_adr    = adr_cur;
  assign b_dat_w  = m_dat_w;
  assign ch_we    = m_we;
  assign ch_adr   = off;
  assign ch_dat_w = m_dat_w;

  assign m_stall  = req & ~m_ack;
  assign m_err    = 1'b0;
  assign m_rty    = 1'b0;

endmodule

// File: rtl/csr_chan_decoder_chk.sv
module csr_chan_decoder_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           m_cyc,
  input logic           m_stb,
  input logic           m_we,
  input logic           m_ack,
  input logic [DW-1:0]  m_dat_r,
  input logic           b_stb,
  input logic           b_ack,
  input logic [NCH-1:0] c_stb,
  input logic [NCH-1:0] c_ack
);

  logic [NCH:0] all_stb;
  assign all_stb = {b_stb, c_stb};

  assert_one_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(all_stb));

  assert_route_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_cyc && m_stb && !m_ack && (|all_stb)) |=>
      (!(m_cyc && m_stb) || (all_stb == $past(all_stb))));

  assert_null_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ack && !m_we && !b_ack && !(|c_ack)) |-> (m_dat_r == '0));

  assert_ack_after_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m_ack |-> $past(m_cyc && m_stb));

  assert_no_double_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    m_ack |=> !m_ack);

endmodule

bind csr_chan_decoder csr_chan_decoder_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .m_cyc   (m_cyc),
  .m_stb   (m_stb),
  .m_we    (m_we),
  .m_ack   (m_ack),
  .m_dat_r (m_dat_r),
  .b_stb   (b_stb),
  .b_ack   (b_ack),
  .c_stb   (c_stb),
  .c_ack   (c_ack)
);

// File: tb/sim_csr_chan_decoder.sv
`timescale 1ns/1ps
module sim_csr_chan_decoder;
  localparam int NCH = 4;
  localparam int DW  = 32;
  localparam int AW  = 9;
  localparam int CH_LAT = 3;
  localparam int MN_LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              m_cyc = 0, m_stb = 0, m_we = 0;
  logic [AW-1:0]     m_adr = '0;
  logic [DW-1:0]     m_dat_w = '0;
  logic [DW-1:0]     m_dat_r;
  logic              m_ack, m_stall, m_err, m_rty;
  logic              b_cyc, b_stb, b_we;
  logic [AW-1:0]     b_adr;
  logic [DW-1:0]     b_dat_w;
  logic [DW-1:0]     b_dat_r;
  logic              b_ack;
  logic [NCH-1:0]    c_cyc, c_stb;
  logic              ch_we;
  logic [4:0]        ch_adr;
  logic [DW-1:0]     ch_dat_w;
  logic [NCH*DW-1:0] c_dat_r;
  logic [NCH-1:0]    c_ack;

  csr_chan_decoder u0 (
    .clk(clk), .rst_n(rst_n), .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we),
    .m_adr(m_adr), .m_dat_w(m_dat_w), .m_dat_r(m_dat_r), .m_ack(m_ack),
    .m_stall(m_stall), .m_err(m_err), .m_rty(m_rty), .b_cyc(b_cyc),
    .b_stb(b_stb), .b_we(b_we), .b_adr(b_adr), .b_dat_w(b_dat_w),
    .b_dat_r(b_dat_r), .b_ack(b_ack), .c_cyc(c_cyc), .c_stb(c_stb),
    .ch_we(ch_we), .ch_adr(ch_adr), .ch_dat_w(ch_dat_w), .c_dat_r(c_dat_r),
    .c_ack(c_ack)
  );

  // subordinate models: plain registers, fixed latency, act on the acking edge
  logic [31:0] ch_mem [NCH][6];
  logic [31:0] ch_rd  [NCH];
  int          ch_cnt [NCH];
  logic [31:0] mn_mem [32];
  logic [31:0] mn_rd;
  int          mn_cnt;
  logic        mn_ackq;
  logic [NCH-1:0] ch_ackq;
  int          stb_cnt;

  for (genvar g = 0; g < NCH; g++) begin : g_rd
    assign c_dat_r[g*DW +: DW] = ch_rd[g];
  end
  assign c_ack   = ch_ackq;
  assign b_ack   = mn_ackq;
  assign b_dat_r = mn_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        for (int w = 0; w < 6; w++) ch_mem[i][w] <= 32'hC000_0000 | (i << 8) | w;
        ch_cnt[i] <= 0;
        ch_rd[i]  <= 32'h0BAD_0000 | i;
      end
      for (int w = 0; w < 32; w++) mn_mem[w] <= 32'hB000_0000 | w;
      ch_ackq <= '0; mn_ackq <= 1'b0; mn_cnt <= 0; mn_rd <= 32'h0BAD_00FF;
      stb_cnt <= 0;
    end else begin
      stb_cnt <= stb_cnt + $countones({b_stb, c_stb});
      for (int i = 0; i < NCH; i++) begin
        if (c_cyc[i] && c_stb[i] && !ch_ackq[i]) begin
          if (ch_cnt[i] == CH_LAT - 1) begin
            ch_ackq[i] <= 1'b1;
            ch_cnt[i]  <= 0;
            if (ch_we) begin
              if (ch_adr[4:2] < 3'd6) ch_mem[i][ch_adr[4:2]] <= ch_dat_w;
            end else begin
              ch_rd[i] <= (ch_adr[4:2] < 3'd6) ? ch_mem[i][ch_adr[4:2]] : 32'h0;
            end
          end else begin
            ch_cnt[i] <= ch_cnt[i] + 1;
          end
        end else begin
          ch_ackq[i] <= 1'b0;
        end
      end
      if (b_cyc && b_stb && !mn_ackq) begin
        if (mn_cnt == MN_LAT - 1) begin
          mn_ackq <= 1'b1;
          mn_cnt  <= 0;
          if (b_we) mn_mem[b_adr[6:2]] <= b_dat_w;
          else      mn_rd <= mn_mem[b_adr[6:2]];
        end else begin
          mn_cnt <= mn_cnt + 1;
        end
      end else begin
        mn_ackq <= 1'b0;
      end
    end
  end

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [AW-1:0] adr, input logic [31:0] dat,
                        output logic [31:0] rdat, output int cyc_n);
    @(negedge clk);
    m_cyc = 1; m_stb = 1; m_we = we; m_adr = adr; m_dat_w = dat;
    cyc_n = 0;
    rdat  = 'x;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      cyc_n++;
      if (m_ack) begin
        rdat = m_dat_r;
        break;
      end
    end
    m_cyc = 0; m_stb = 0; m_we = 0;
  endtask

  // {we, adr, write data, expected read}
  localparam int NV = 13;
  localparam logic [79:0] TBL [NV] = '{
    {4'h1, 12'h090, 32'h1111_0001, 32'h0},
    {4'h1, 12'h0D0, 32'h2222_0002, 32'h0},
    {4'h1, 12'h110, 32'h3333_0003, 32'h0},
    {4'h1, 12'h150, 32'h4444_0004, 32'h0},
    {4'h1, 12'h010, 32'h5555_0005, 32'h0},
    {4'h0, 12'h090, 32'h0, 32'h1111_0001},
    {4'h0, 12'h0D0, 32'h0, 32'h2222_0002},
    {4'h0, 12'h110, 32'h0, 32'h3333_0003},
    {4'h0, 12'h150, 32'h0, 32'h4444_0004},
    {4'h0, 12'h010, 32'h0, 32'h5555_0005},
    {4'h0, 12'h084, 32'h0, 32'hC000_0001},
    {4'h0, 12'h154, 32'h0, 32'hC000_0305},
    {4'h0, 12'h07C, 32'h0, 32'hB000_001F}
  };

  initial begin
    #(4 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int cy, s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 idle after reset, R8 err/rty
    check("R10 ack", {31'b0, m_ack}, 32'h0);
    check("R10 stall", {31'b0, m_stall}, 32'h0);
    check("R10 strobes", {27'b0, b_stb, c_stb}, 32'h0);
    check("R8 err/rty", {30'b0, m_err, m_rty}, 32'h0);

    // R1, R2, R4: vector table
    for (int k = 0; k < NV; k++) begin
      logic [79:0] e;
      e = TBL[k];
      access(e[76], e[72:64], e[63:32], rd, cy);
      if (!e[76]) check(e[72:64] < 9'h080 ? "R1 main readback" : "R2 window readback", rd, e[31:0]);
      else        check("R4 write acked", {31'b0, cy < 40}, 32'h1);
    end

    // R5 null responder
    s0 = stb_cnt;
    access(1'b1, 9'h098, 32'hFEED_0098, rd, cy);
    check("R5 null write latency", cy, 1);
    access(1'b0, 9'h098, 32'h0, rd, cy);
    check("R5 spare word reads zero", rd, 32'h0);
    access(1'b0, 9'h0A0, 32'h0, rd, cy);
    check("R5 gap reads zero", rd, 32'h0);
    access(1'b0, 9'h1F0, 32'h0, rd, cy);
    check("R5 top reads zero", rd, 32'h0);
    check("R5 no subordinate strobed", stb_cnt - s0, 0);
    access(1'b0, 9'h094, 32'h0, rd, cy);
    check("R5 neighbour word intact", rd, 32'hC000_0005);

    // R6 stall, R3 single strobe, R2 rebased offset
    @(negedge clk);
    m_cyc = 1; m_stb = 1; m_we = 0; m_adr = 9'h0C4;
    #1;
    check("R6 stall while waiting", {31'b0, m_stall}, 32'h1);
    check("R3 only channel 1 strobed", {27'b0, b_stb, c_stb}, 32'h2);
    check("R2 rebased offset", {27'b0, ch_adr}, 32'h4);
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (m_ack) break;
    end
    check("R6 stall low on ack", {31'b0, m_stall}, 32'h0);
    m_cyc = 0; m_stb = 0;

    // R7 address moved mid-write towards the main bank
    @(negedge clk);
    m_cyc = 1; m_stb = 1; m_we = 1; m_adr = 9'h110; m_dat_w = 32'hDEAD_0007;
    @(negedge clk);
    m_adr = 9'h010;
    #1;
    check("R7 main not strobed", {31'b0, b_stb}, 32'h0);
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (m_ack) break;
    end
    m_cyc = 0; m_stb = 0; m_we = 0;
    access(1'b0, 9'h110, 32'h0, rd, cy);
    check("R7 held target written", rd, 32'hDEAD_0007);
    access(1'b0, 9'h010, 32'h0, rd, cy);
    check("R7 main untouched", rd, 32'h5555_0005);

    // R9 back-to-back reads, request held over the ack
    @(negedge clk);
    m_cyc = 1; m_stb = 1; m_we = 0; m_adr = 9'h0C4;
    rd = 'x;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (m_ack) begin rd = m_dat_r; break; end
    end
    check("R9 first read", rd, 32'hC000_0101);
    m_adr = 9'h150;
    @(negedge clk);
    check("R9 no ack after ack", {31'b0, m_ack}, 32'h0);
    check("R9 re-decoded to channel 3", {27'b0, b_stb, c_stb}, 32'h8);
    rd = 'x;
    for (int n = 0; n < 40; n++) begin
      if (m_ack) begin rd = m_dat_r; break; end
      @(negedge clk);
    end
    check("R9 second read", rd, 32'h4444_0004);
    m_cyc = 0; m_stb = 0;
    @(negedge clk);
    check("R8 err/rty after traffic", {30'b0, m_err, m_rty}, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule